// File: doc/BRIEF.md
# Base Address Window Validity Decoder

This block sits beside the configuration registers of a bus endpoint. It watches the two space-enable bits of the command register and a set of base-address registers: several ordinary regions plus, when configured, an expansion-ROM region in the highest slot. From these it works out, for every region, whether a window is currently open and at which aligned base. Each region has a fixed size, which is a power of two, and a fixed space type, IO or memory. Both are set by parameters. A region whose size is given as zero is not implemented.

The window state is held in registers. It follows the register inputs one clock edge later. Whenever a region's validity or base changes, that region raises a one-cycle remap pulse, so the fabric can retarget its routing. Incoming transaction addresses, tagged as IO or memory, are decoded without a clock against the open windows. The decoder reports a hit and the index of the matching region. When windows overlap, the lowest-numbered region wins.

Top module: `bar_window_decoder`

## Requirements
- R1: An IO region can be open only while command-enable bit 0 (`cmdSpaceEn[0]`) is 1. A memory region, including the ROM, can be open only while bit 1 is 1.
- R2: A region's base is its register value with the low log2(size) bits cleared. The reported base of a region that is not open is zero.
- R3: An IO window is closed when its aligned base is zero, when base plus size minus one wraps, or when its last address is 0x10000 or above. A window whose last address is exactly 0xFFFF stays open.
- R4: A memory window is closed when its aligned base is zero, when it wraps, or when its last address is all ones.
- R5: The expansion-ROM region (the highest index, when present) additionally needs bit 0 of its register set to be open.
- R6: A region configured with size zero is never open and never produces a hit, whatever its register holds.
- R7: `hit` is 1 when the transaction's space type equals a region's type, that region is open, and the address lies between its base and base plus size minus one. `hitIdx` then gives that region's index.
- R8: When several open windows match one address, `hitIdx` reports the lowest-numbered one.
- R9: Window validity and base take new register values on the next rising clock edge. In the cycle after that edge, `remap` has a 1 for exactly the regions whose validity or base changed. It has a 0 for any region whose write changed neither.
- R10: `hit` and `hitIdx` follow `txnAddr` and `txnIsIo` with no clock edge. `hitIdx` is 0 when there is no hit.
- R11: While reset is asserted, every region reads closed with base zero, and `remap` and `hit` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdSpaceEn | input | 2 | Command enables: bit 0 IO space, bit 1 memory space |
| barFlat | input | NUM_REGIONS*ADDR_W | Base-address register values, region 0 in the low bits |
| txnAddr | input | ADDR_W | Transaction address to decode |
| txnIsIo | input | 1 | 1 for an IO transaction, 0 for memory |
| winValid | output | NUM_REGIONS | Per-region window open |
| winBase | output | NUM_REGIONS*ADDR_W | Per-region aligned base, zero when closed |
| remap | output | NUM_REGIONS | One-cycle pulse per region on a change of validity or base |
| hit | output | 1 | Transaction address falls in an open window of its space |
| hitIdx | output | $clog2(NUM_REGIONS) | Index of the winning region |

## Verification
The decode is tried with addresses inside a window, one byte past its end, in the wrong space type, and in a spot covered by two overlapping memory windows. Together these separate the range compare, the space-type match and the priority order. Register patterns then move each window onto its edge cases: zero base, IO last address exactly 0xFFFF against 0x10000, a memory window ending at all ones against one a step lower, a ROM with its enable bit cleared, and an unimplemented region with a base written. Each of these shows up in validity, base and decode. Toggling each command enable on its own shows that only the regions of that space close and pulse `remap`. A rewrite that changes only masked low bits shows that no pulse is raised.

// File: rtl/bar_win_pkg.sv
package bar_win_pkg;

  // Command-register bit positions decoded by this block.
  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;
  // Enable bit inside the expansion-ROM base register.
  localparam int ROM_EN_BIT  = 0;

  // Strobes from control to datapath.
  typedef struct packed {
    logic commit;   // load candidate window state into the held state
  } win_strobe_t;

endpackage

// File: rtl/bar_win_dp.sv
module bar_win_dp
  import bar_win_pkg::*;
#(
  parameter int NUM_REGIONS   = 7,
  parameter int ADDR_W        = 32,
  parameter int LOG2_W        = 5,
  parameter logic [NUM_REGIONS*LOG2_W-1:0] SIZE_LOG2 = '0,
  parameter logic [NUM_REGIONS-1:0] IS_IO = '0,
  parameter bit   HAS_ROM       = 1'b1,
  parameter int   IO_SPACE_LOG2 = 16,
  parameter int   IDX_W         = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    cmdSpaceEn,
  input  logic [NUM_REGIONS*ADDR_W-1:0] barFlat,
  input  win_strobe_t                   strobe,
  input  logic [ADDR_W-1:0]             txnAddr,
  input  logic                          txnIsIo,
  output logic [NUM_REGIONS-1:0]        candValid,
  output logic [NUM_REGIONS*ADDR_W-1:0] candBase,
  output logic [NUM_REGIONS-1:0]        curValid,
  output logic [NUM_REGIONS*ADDR_W-1:0] curBase,
  output logic                          hit,
  output logic [IDX_W-1:0]              hitIdx
);

  localparam logic [ADDR_W:0] IO_LIMIT = (ADDR_W+1)'(1) << IO_SPACE_LOG2;

  logic [NUM_REGIONS-1:0] match;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    localparam int  L       = int'(SIZE_LOG2[i*LOG2_W +: LOG2_W]);
    localparam bit  PRESENT = (L != 0);
    localparam bit  ISIO    = IS_IO[i];
    localparam bit  ISROM   = HAS_ROM && (i == NUM_REGIONS-1);
    localparam logic [ADDR_W-1:0] LOWMASK = (ADDR_W'(1) << L) - ADDR_W'(1);

    logic [ADDR_W-1:0] barVal;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W:0]   lastAddr;
    logic              wraps;
    logic              spaceOk;
    logic              limitOk;

    assign barVal   = barFlat[i*ADDR_W +: ADDR_W];
    assign aligned  = barVal & ~LOWMASK;
    assign lastAddr = {1'b0, aligned} + {1'b0, LOWMASK};
    assign wraps    = lastAddr[ADDR_W];

    if (ISIO) begin : g_io
      assign spaceOk = cmdSpaceEn[CMD_IO_BIT];
      assign limitOk = (lastAddr < IO_LIMIT);
    end else begin : g_mem
      assign spaceOk = cmdSpaceEn[CMD_MEM_BIT] && (!ISROM || barVal[ROM_EN_BIT]);
      assign limitOk = (lastAddr[ADDR_W-1:0] != '1);
    end

    assign candValid[i] = PRESENT && spaceOk && limitOk && !wraps && (aligned != '0);
    assign candBase[i*ADDR_W +: ADDR_W] = candValid[i] ? aligned : '0;

    assign match[i] = curValid[i] && (txnIsIo == ISIO) &&
                      ((txnAddr & ~LOWMASK) == curBase[i*ADDR_W +: ADDR_W]);

    // R1: an open IO window implies the IO enable was set at the last load
    if (ISIO) begin : g_chk_io
      a_r1_io_enable: assert property (@(posedge clk) disable iff (!rstN)
        curValid[i] |-> $past(cmdSpaceEn[CMD_IO_BIT]));
      // R3: an open IO window ends below the IO space limit
      a_r3_io_limit: assert property (@(posedge clk) disable iff (!rstN)
        curValid[i] |-> (({1'b0, curBase[i*ADDR_W +: ADDR_W]} + {1'b0, LOWMASK}) < IO_LIMIT));
    end else begin : g_chk_mem
      a_r1_mem_enable: assert property (@(posedge clk) disable iff (!rstN)
        curValid[i] |-> $past(cmdSpaceEn[CMD_MEM_BIT]));
    end
    if (ISROM) begin : g_chk_rom
      // R5: open ROM window implies its enable bit was set
      a_r5_rom_enable: assert property (@(posedge clk) disable iff (!rstN)
        curValid[i] |-> $past(barVal[ROM_EN_BIT]));
    end
  end

  // Held window state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curValid <= '0;
      curBase  <= '0;
    end else if (strobe.commit) begin
      curValid <= candValid;
      curBase  <= candBase;
    end
  end

  // Priority decode: lowest index wins
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = NUM_REGIONS-1; i >= 0; i--) begin
      if (match[i]) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  // R10: a reported hit always names an open region
  a_r10_hit_open: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> curValid[hitIdx]);

endmodule

// File: rtl/bar_win_ctl.sv
module bar_win_ctl
  import bar_win_pkg::*;
#(
  parameter int NUM_REGIONS = 7,
  parameter int ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_REGIONS-1:0]        candValid,
  input  logic [NUM_REGIONS*ADDR_W-1:0] candBase,
  input  logic [NUM_REGIONS-1:0]        curValid,
  input  logic [NUM_REGIONS*ADDR_W-1:0] curBase,
  output win_strobe_t                   strobe,
  output logic [NUM_REGIONS-1:0]        remap
);

  logic [NUM_REGIONS-1:0] changed;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
    assign changed[i] = (candValid[i] != curValid[i]) ||
                        (candBase[i*ADDR_W +: ADDR_W] != curBase[i*ADDR_W +: ADDR_W]);
  end

  assign strobe.commit = |changed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) remap <= '0;
    else       remap <= changed;
  end

  // R9: any movement of held validity comes with a remap pulse
  a_r9_remap_on_move: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curValid) |-> (remap != '0));

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
  import bar_win_pkg::*;
#(
  parameter int NUM_REGIONS   = 7,
  parameter int ADDR_W        = 32,
  parameter int LOG2_W        = 5,
  // log2 of each region's size, region 0 in the low bits; 0 = not implemented
  parameter logic [NUM_REGIONS*LOG2_W-1:0] SIZE_LOG2 =
    {5'd16, 5'd0, 5'd8, 5'd0, 5'd20, 5'd12, 5'd5},
  parameter logic [NUM_REGIONS-1:0] IS_IO = 7'b0010001,
  parameter bit   HAS_ROM       = 1'b1,
  parameter int   IO_SPACE_LOG2 = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    cmdSpaceEn,
  input  logic [NUM_REGIONS*ADDR_W-1:0] barFlat,
  input  logic [ADDR_W-1:0]             txnAddr,
  input  logic                          txnIsIo,
  output logic [NUM_REGIONS-1:0]        winValid,
  output logic [NUM_REGIONS*ADDR_W-1:0] winBase,
  output logic [NUM_REGIONS-1:0]        remap,
  output logic                          hit,
  output logic [$clog2(NUM_REGIONS)-1:0] hitIdx
);

  localparam int IDX_W = $clog2(NUM_REGIONS);

  win_strobe_t                   strobe;
  logic [NUM_REGIONS-1:0]        candValid;
  logic [NUM_REGIONS*ADDR_W-1:0] candBase;

  bar_win_ctl #(
    .NUM_REGIONS(NUM_REGIONS),
    .ADDR_W     (ADDR_W)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .candValid(candValid),
    .candBase (candBase),
    .curValid (winValid),
    .curBase  (winBase),
    .strobe   (strobe),
    .remap    (remap)
  );

  bar_win_dp #(
    .NUM_REGIONS  (NUM_REGIONS),
    .ADDR_W       (ADDR_W),
    .LOG2_W       (LOG2_W),
    .SIZE_LOG2    (SIZE_LOG2),
    .IS_IO        (IS_IO),
    .HAS_ROM      (HAS_ROM),
    .IO_SPACE_LOG2(IO_SPACE_LOG2),
    .IDX_W        (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmdSpaceEn(cmdSpaceEn),
    .barFlat   (barFlat),
    .strobe    (strobe),
    .txnAddr   (txnAddr),
    .txnIsIo   (txnIsIo),
    .candValid (candValid),
    .candBase  (candBase),
    .curValid  (winValid),
    .curBase   (winBase),
    .hit       (hit),
    .hitIdx    (hitIdx)
  );

endmodule

// File: tb/test_bar_window_decoder.sv
`timescale 1ns/1ps
module test_bar_window_decoder;

  logic         clk = 1'b0;
  logic         rstN;
  logic [1:0]   cmdSpaceEn;
  logic [223:0] barFlat;
  logic [31:0]  txnAddr;
  logic         txnIsIo;
  logic [6:0]   winValid;
  logic [223:0] winBase;
  logic [6:0]   remap;
  logic         hit;
  logic [2:0]   hitIdx;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  bar_window_decoder i_bar_window_decoder (
    .clk(clk), .rstN(rstN), .cmdSpaceEn(cmdSpaceEn), .barFlat(barFlat),
    .txnAddr(txnAddr), .txnIsIo(txnIsIo), .winValid(winValid),
    .winBase(winBase), .remap(remap), .hit(hit), .hitIdx(hitIdx)
  );

  // {addr, isIo, expHit, expIdx}
  localparam logic [36:0] VEC [8] = '{
    {32'h0000_1004, 1'b1, 1'b1, 3'd0},  // IO region 0 inside
    {32'h0000_1004, 1'b0, 1'b0, 3'd0},  // wrong space type
    {32'h8000_0010, 1'b0, 1'b1, 3'd1},  // overlap 1 and 2, lowest wins
    {32'h8000_2000, 1'b0, 1'b1, 3'd2},  // only region 2
    {32'h0000_2010, 1'b1, 1'b1, 3'd4},  // IO region 4
    {32'hC000_FFFC, 1'b0, 1'b1, 3'd6},  // ROM window top
    {32'hC001_0000, 1'b0, 1'b0, 3'd0},  // one past ROM window
    {32'h0000_1020, 1'b1, 1'b0, 3'd0}   // one past region 0
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setBar(input int idx, input logic [31:0] val);
    barFlat[idx*32 +: 32] = val;
  endtask

  function automatic logic [31:0] baseOf(input int idx);
    return winBase[idx*32 +: 32];
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic decode(input logic [31:0] a, input logic io);
    txnAddr = a;
    txnIsIo = io;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    cmdSpaceEn = 2'b11;
    barFlat = '0;
    setBar(0, 32'h0000_1001);
    setBar(1, 32'h8000_0000);
    setBar(2, 32'h8000_0000);
    setBar(4, 32'h0000_2000);
    setBar(6, 32'hC000_0001);
    txnAddr = 32'h0000_1004;
    txnIsIo = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "valid in reset", 64'(winValid), 64'h0);
    chk("R11", "base in reset", 64'(winBase[63:0]), 64'h0);
    chk("R11", "remap in reset", 64'(remap), 64'h0);
    chk("R11", "hit in reset", 64'(hit), 64'h0);

    @(negedge clk) rstN = 1'b1;
    step();
    chk("R9", "valid after first edge", 64'(winValid), 64'h57);
    chk("R9", "remap after first edge", 64'(remap), 64'h57);
    chk("R2", "base0", 64'(baseOf(0)), 64'h1000);
    chk("R2", "base1", 64'(baseOf(1)), 64'h8000_0000);
    chk("R2", "base6", 64'(baseOf(6)), 64'hC000_0000);
    chk("R6", "base3 unused", 64'(baseOf(3)), 64'h0);
    step();
    chk("R9", "remap drops", 64'(remap), 64'h0);

    for (int k = 0; k < 8; k++) begin
      decode(VEC[k][36:5], VEC[k][4]);
      chk("R7 R8 R10", $sformatf("hit vec %0d", k), 64'(hit), 64'(VEC[k][3]));
      chk("R7 R8 R10", $sformatf("idx vec %0d", k), 64'(hitIdx), 64'(VEC[k][2:0]));
    end

    // R1: IO enable off
    @(negedge clk) cmdSpaceEn = 2'b10;
    step();
    chk("R1", "valid IO off", 64'(winValid), 64'h46);
    chk("R1", "remap IO off", 64'(remap), 64'h11);
    decode(32'h0000_1004, 1'b1);
    chk("R1", "no IO hit", 64'(hit), 64'h0);
    @(negedge clk) cmdSpaceEn = 2'b01;
    step();
    chk("R1", "valid mem off", 64'(winValid), 64'h11);
    @(negedge clk) cmdSpaceEn = 2'b11;
    step();
    chk("R1", "valid restored", 64'(winValid), 64'h57);

    // R2/R9: masked low bits change nothing
    step();
    @(negedge clk) setBar(1, 32'h8000_0ABC);
    step();
    chk("R2", "low bits masked", 64'(baseOf(1)), 64'h8000_0000);
    chk("R9", "no remap", 64'(remap), 64'h0);

    // R4: memory edge cases
    @(negedge clk) setBar(1, 32'h0000_0FFF);
    step();
    chk("R4", "zero base closed", 64'(winValid[1]), 64'h0);
    chk("R2", "closed base zero", 64'(baseOf(1)), 64'h0);
    chk("R9", "remap region1", 64'(remap), 64'h02);
    @(negedge clk) setBar(1, 32'hFFFF_F000);
    step();
    chk("R4", "all-ones end closed", 64'(winValid[1]), 64'h0);
    @(negedge clk) setBar(1, 32'hFFFF_E000);
    step();
    chk("R4", "below top open", 64'(winValid[1]), 64'h1);
    chk("R2", "base top-1", 64'(baseOf(1)), 64'hFFFF_E000);
    decode(32'hFFFF_EFFF, 1'b0);
    chk("R7", "hit top window", 64'(hit), 64'h1);
    chk("R7", "idx top window", 64'(hitIdx), 64'h1);

    // R3: IO edge cases
    @(negedge clk) setBar(4, 32'h0001_0000);
    step();
    chk("R3", "IO above 64K closed", 64'(winValid[4]), 64'h0);
    @(negedge clk) setBar(4, 32'h0000_FF00);
    step();
    chk("R3", "IO ending at FFFF open", 64'(winValid[4]), 64'h1);
    decode(32'h0000_FFFF, 1'b1);
    chk("R3", "IO hit last byte", 64'(hitIdx), 64'h4);
    @(negedge clk) setBar(4, 32'h0000_0010);
    step();
    chk("R3", "IO zero base closed", 64'(winValid[4]), 64'h0);

    // R5: ROM enable bit
    @(negedge clk) setBar(6, 32'hC000_0000);
    step();
    chk("R5", "ROM disabled", 64'(winValid[6]), 64'h0);
    chk("R5", "ROM base zero", 64'(baseOf(6)), 64'h0);
    decode(32'hC000_0010, 1'b0);
    chk("R5", "no ROM hit", 64'(hit), 64'h0);
    @(negedge clk) setBar(6, 32'hC000_0001);
    step();
    chk("R5", "ROM enabled", 64'(winValid[6]), 64'h1);

    // R6: unimplemented region
    @(negedge clk) setBar(3, 32'h4000_0000);
    step();
    chk("R6", "unused stays closed", 64'(winValid[3]), 64'h0);
    decode(32'h4000_0000, 1'b0);
    chk("R6", "unused no hit", 64'(hit), 64'h0);
    chk("R10", "idx zero on miss", 64'(hitIdx), 64'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule